// File: doc/BRIEF.md
# Local Memory Read Steering Unit

This block decides where each processor read is served from. A read address goes to four possible sources: a tightly coupled SRAM window, a tightly coupled ROM window, an instruction cache, and external system memory. The SRAM and ROM window checks and the cache lookup all run in the same cycle as the request. A fixed priority then picks one source. The SRAM window wins over the ROM window, the ROM window wins over the cache, and the cache wins over system memory. The data of every losing source is dropped.

Each window is set by a configuration write. The write carries a base address, a size mask whose set bits mark the offset bits inside the window, and a valid bit. When the lookups all miss, the block raises a system memory request and holds the address until the acknowledge arrives. It allows only one such request at a time. Only data that comes back from system memory may be written into the cache. The SRAM, ROM and cache arrays sit outside the block and answer combinationally on the request address.

Top module: `lmem_read_steer`

## Requirements
- R1: After reset both windows are invalid, `reqReady` is 1 and `sysReq`, `rspValid` and `cacheFillEn` are 0. A read inside a window that has not been configured is served by the cache, or by system memory if the cache misses.
- R2: When a read is accepted and the SRAM window hits, `rspValid` is 1 in the same cycle, `rspData` equals `sramData` and `rspSrc` is 0. This holds even if the ROM window or the cache also hits, and no system request is made.
- R3: When the SRAM window misses and the ROM window hits, the accepted read returns `romData` in the same cycle with `rspSrc` = 1, even if the cache also hits.
- R4: When both windows miss and `cacheHit` is 1, the accepted read returns `cacheData` in the same cycle with `rspSrc` = 2.
- R5: When all three lookups miss, `rspValid` stays 0. From the next cycle `sysReq` is 1 and `sysAddr` holds the request address. Both stay unchanged, and `reqReady` stays 0, until `sysAck` arrives.
- R6: In the cycle `sysAck` arrives during a pending system request, `rspValid` is 1, `rspData` equals `sysData` and `rspSrc` is 3. In the next cycle `sysReq` is 0 and `reqReady` is 1.
- R7: `cacheFillEn` is 1 only in the completion cycle of a system memory request. It is never 1 for data from the SRAM window, the ROM window or the cache.
- R8: A window hits when `valid` is set and `(addr & ~mask) == (base & ~mask)`. Base bits under the mask have no effect. A window written with `valid` = 0 never hits.
- R9: A configuration write with `cfgWrEn` = 1 goes to the SRAM window when `cfgSel` = 0 and to the ROM window when `cfgSel` = 1. It affects lookups from the next cycle on.
- R10: `sysAck` has no effect while no system request is pending. `rspValid` and `cacheFillEn` stay 0.
- R11: While `reqValid` is 0 and no system request is pending, `rspValid` is 0 and no system request starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Window configuration write strobe |
| cfgSel | input | 1 | Window select: 0 SRAM, 1 ROM |
| cfgBase | input | 32 | Window base address |
| cfgMask | input | 32 | Window size mask (set bits are offset bits) |
| cfgValid | input | 1 | Window enable |
| reqValid | input | 1 | Read request present |
| reqAddr | input | 32 | Read address |
| reqReady | output | 1 | Block can accept a read |
| sramData | input | 32 | SRAM responder data for `reqAddr` |
| romData | input | 32 | ROM responder data for `reqAddr` |
| cacheHit | input | 1 | Cache lookup hit for `reqAddr` |
| cacheData | input | 32 | Cache responder data |
| sysReq | output | 1 | System memory request pending |
| sysAddr | output | 32 | System memory read address |
| sysAck | input | 1 | System memory completion |
| sysData | input | 32 | System memory read data |
| rspValid | output | 1 | Read data valid, one-cycle pulse |
| rspData | output | 32 | Read data |
| rspSrc | output | 2 | Source of the data: 0 SRAM, 1 ROM, 2 cache, 3 system |
| cacheFillEn | output | 1 | Allocate `rspData` at `sysAddr` into the cache |

## Verification
The vectors include reads that hit several sources at once: SRAM against ROM and cache, and ROM against cache. A wrong priority order would return the wrong data or source code. Reads at the first and last word of each window and just past the end catch mask compares that are off by one bit. A ROM base with bits set under the mask catches a compare that ignores the mask. The directed tests issue reads before any configuration and after a window is disabled, which catches a window that hits while invalid. They also send a stray acknowledge with nothing pending, which catches a block that raises a response or a cache fill for it. During system memory waits the bench checks that the address is held and the block stays stalled until the acknowledge.

// File: rtl/lmem_steer_pkg.sv
package lmem_steer_pkg;

  localparam int NUM_REGIONS = 2;
  localparam int REG_SRAM    = 0;
  localparam int REG_ROM     = 1;

  typedef enum logic [1:0] {
    SRC_SRAM  = 2'd0,
    SRC_ROM   = 2'd1,
    SRC_CACHE = 2'd2,
    SRC_SYS   = 2'd3
  } srcSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic acceptLocal;  // read served by a local source this cycle
    logic acceptMiss;   // read missed everywhere, capture address
    logic sysDone;      // system memory completion this cycle
  } steerStrobe_t;

endpackage

// File: rtl/lmem_region_match.sv
module lmem_region_match #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrBase,
  input  logic [AW-1:0] wrMask,
  input  logic          wrValid,
  input  logic [AW-1:0] lookupAddr,
  output logic          hit
);

  logic [AW-1:0] baseQ;
  logic [AW-1:0] maskQ;
  logic          validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ  <= '0;
      maskQ  <= '0;
      validQ <= 1'b0;
    end else if (wrEn) begin
      baseQ  <= wrBase;
      maskQ  <= wrMask;
      validQ <= wrValid;
    end
  end

  assign hit = validQ && ((lookupAddr & ~maskQ) == (baseQ & ~maskQ));

endmodule

// File: rtl/lmem_steer_dp.sv
module lmem_steer_dp
  import lmem_steer_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWrEn,
  input  logic          cfgSel,
  input  logic [AW-1:0] cfgBase,
  input  logic [AW-1:0] cfgMask,
  input  logic          cfgValid,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] sramData,
  input  logic [DW-1:0] romData,
  input  logic          cacheHit,
  input  logic [DW-1:0] cacheData,
  input  logic [DW-1:0] sysData,
  input  steerStrobe_t  strb,
  output logic          localHit,
  output logic [AW-1:0] sysAddr,
  output logic [DW-1:0] rspData,
  output logic [1:0]    rspSrc
);

  logic [NUM_REGIONS-1:0] regionHit;
  logic [AW-1:0]          missAddrQ;
  srcSel_e                srcSel;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    lmem_region_match #(.AW(AW)) u_region (
      .clk        (clk),
      .rstN       (rstN),
      .wrEn       (cfgWrEn && (int'(cfgSel) == g)),
      .wrBase     (cfgBase),
      .wrMask     (cfgMask),
      .wrValid    (cfgValid),
      .lookupAddr (reqAddr),
      .hit        (regionHit[g])
    );
  end

  assign localHit = regionHit[REG_SRAM] | regionHit[REG_ROM] | cacheHit;

  // Fixed priority: pending completion, then SRAM, ROM, cache
  always_comb begin
    if (strb.sysDone)               srcSel = SRC_SYS;
    else if (regionHit[REG_SRAM])   srcSel = SRC_SRAM;
    else if (regionHit[REG_ROM])    srcSel = SRC_ROM;
    else if (cacheHit)              srcSel = SRC_CACHE;
    else                            srcSel = SRC_SYS;
  end

  always_comb begin
    unique case (srcSel)
      SRC_SRAM:  rspData = sramData;
      SRC_ROM:   rspData = romData;
      SRC_CACHE: rspData = cacheData;
      default:   rspData = sysData;
    endcase
  end

  assign rspSrc = srcSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                missAddrQ <= '0;
    else if (strb.acceptMiss) missAddrQ <= reqAddr;
  end

  assign sysAddr = missAddrQ;

  AST_SRAM_OVER_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (strb.acceptLocal && regionHit[REG_SRAM]) |-> (rspSrc == SRC_SRAM)); // R2
  AST_ROM_OVER_CACHE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.acceptLocal && !regionHit[REG_SRAM] && regionHit[REG_ROM]) |-> (rspSrc == SRC_ROM)); // R3
  AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !cfgSel && !cfgValid) |=> !regionHit[REG_SRAM]); // R8
  AST_MISS_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.acceptMiss) |=> $stable(sysAddr)); // R5

endmodule

// File: rtl/lmem_steer_ctrl.sv
module lmem_steer_ctrl
  import lmem_steer_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         localHit,
  input  logic         sysAck,
  output logic         reqReady,
  output logic         sysReq,
  output logic         rspValid,
  output logic         cacheFillEn,
  output steerStrobe_t strb
);

  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} ctrlState_e;

  ctrlState_e stateQ, stateD;

  always_comb begin
    strb.acceptLocal = (stateQ == ST_IDLE) && reqValid && localHit;
    strb.acceptMiss  = (stateQ == ST_IDLE) && reqValid && !localHit;
    strb.sysDone     = (stateQ == ST_WAIT) && sysAck;
  end

  always_comb begin
    stateD = stateQ;
    if (strb.acceptMiss)   stateD = ST_WAIT;
    else if (strb.sysDone) stateD = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign reqReady    = (stateQ == ST_IDLE);
  assign sysReq      = (stateQ == ST_WAIT);
  assign rspValid    = strb.acceptLocal | strb.sysDone;
  assign cacheFillEn = strb.sysDone;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (sysReq && !sysAck) |=> sysReq); // R5
  AST_STALL_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    sysReq |-> !reqReady); // R5
  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (sysReq && sysAck) |=> (!sysReq && reqReady)); // R6
  AST_FILL_ONLY_SYS: assert property (@(posedge clk) disable iff (!rstN)
    cacheFillEn |-> (sysReq && rspValid)); // R7
  AST_STRAY_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (!sysReq && !reqValid) |-> (!rspValid && !cacheFillEn)); // R10 R11
  AST_MISS_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !localHit) |=> sysReq); // R5

endmodule

// File: rtl/lmem_read_steer.sv
module lmem_read_steer
  import lmem_steer_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWrEn,
  input  logic          cfgSel,
  input  logic [AW-1:0] cfgBase,
  input  logic [AW-1:0] cfgMask,
  input  logic          cfgValid,
  input  logic          reqValid,
  input  logic [AW-1:0] reqAddr,
  output logic          reqReady,
  input  logic [DW-1:0] sramData,
  input  logic [DW-1:0] romData,
  input  logic          cacheHit,
  input  logic [DW-1:0] cacheData,
  output logic          sysReq,
  output logic [AW-1:0] sysAddr,
  input  logic          sysAck,
  input  logic [DW-1:0] sysData,
  output logic          rspValid,
  output logic [DW-1:0] rspData,
  output logic [1:0]    rspSrc,
  output logic          cacheFillEn
);

  steerStrobe_t strb;
  logic         localHit;

  lmem_steer_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .localHit    (localHit),
    .sysAck      (sysAck),
    .reqReady    (reqReady),
    .sysReq      (sysReq),
    .rspValid    (rspValid),
    .cacheFillEn (cacheFillEn),
    .strb        (strb)
  );

  lmem_steer_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgSel    (cfgSel),
    .cfgBase   (cfgBase),
    .cfgMask   (cfgMask),
    .cfgValid  (cfgValid),
    .reqAddr   (reqAddr),
    .sramData  (sramData),
    .romData   (romData),
    .cacheHit  (cacheHit),
    .cacheData (cacheData),
    .sysData   (sysData),
    .strb      (strb),
    .localHit  (localHit),
    .sysAddr   (sysAddr),
    .rspData   (rspData),
    .rspSrc    (rspSrc)
  );

endmodule

// File: tb/lmem_read_steer_tb.sv
module lmem_read_steer_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0, cfgSel = 1'b0, cfgValid = 1'b0;
  logic [31:0] cfgBase = '0, cfgMask = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqReady;
  logic [31:0] sramData, romData, cacheData;
  logic        cacheHit = 1'b0;
  logic        sysReq;
  logic [31:0] sysAddr;
  logic        sysAck = 1'b0;
  logic [31:0] sysData = '0;
  logic        rspValid;
  logic [31:0] rspData;
  logic [1:0]  rspSrc;
  logic        cacheFillEn;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  // Simple responders keyed on the address
  assign sramData  = reqAddr ^ 32'hA5A5_0000;
  assign romData   = reqAddr ^ 32'h5A5A_0000;
  assign cacheData = reqAddr ^ 32'h0F0F_0000;

  lmem_read_steer u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgBase(cfgBase), .cfgMask(cfgMask), .cfgValid(cfgValid),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqReady(reqReady),
    .sramData(sramData), .romData(romData), .cacheHit(cacheHit),
    .cacheData(cacheData), .sysReq(sysReq), .sysAddr(sysAddr),
    .sysAck(sysAck), .sysData(sysData), .rspValid(rspValid),
    .rspData(rspData), .rspSrc(rspSrc), .cacheFillEn(cacheFillEn)
  );

  // {expected source, cacheHit, address}
  localparam logic [34:0] VEC [0:7] = '{
    {2'd0, 1'b1, 32'h1000_0000},
    {2'd0, 1'b0, 32'h1000_0FFF},
    {2'd1, 1'b1, 32'h1000_1000},
    {2'd1, 1'b0, 32'h100F_FFFC},
    {2'd2, 1'b1, 32'h1010_0000},
    {2'd2, 1'b1, 32'h3000_0040},
    {2'd3, 1'b0, 32'h1010_0000},
    {2'd3, 1'b0, 32'h7FFF_FFF0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expData(input logic [1:0] src, input logic [31:0] a);
    case (src)
      2'd0:    return a ^ 32'hA5A5_0000;
      2'd1:    return a ^ 32'h5A5A_0000;
      2'd2:    return a ^ 32'h0F0F_0000;
      default: return a ^ 32'hC3C3_0000;
    endcase
  endfunction

  task automatic cfgWrite(input logic sel, input logic [31:0] base, input logic [31:0] mask,
                          input logic valid);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgBase = base; cfgMask = mask; cfgValid = valid;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // One read; expects the given source
  task automatic doRead(input string tag, input logic [31:0] a, input logic hitC,
                        input logic [1:0] src);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; cacheHit = hitC;
    #1;
    chk({tag, " ready"}, 32'(reqReady), 32'd1);
    if (src != 2'd3) begin
      chk({tag, " rspValid"}, 32'(rspValid), 32'd1);
      chk({tag, " rspSrc"}, 32'(rspSrc), 32'(src));
      chk({tag, " rspData"}, rspData, expData(src, a));
      chk({tag, " R7 fill"}, 32'(cacheFillEn), 32'd0);
      @(negedge clk);
      reqValid = 1'b0; cacheHit = 1'b0;
      #1;
      chk({tag, " R11 idle"}, {30'd0, rspValid, sysReq}, 32'd0);
    end else begin
      chk({tag, " R5 no rsp"}, 32'(rspValid), 32'd0);
      @(negedge clk);
      reqValid = 1'b0; cacheHit = 1'b0; reqAddr = 32'h1000_0000;
      for (int w = 0; w < 3; w++) begin
        #1;
        chk({tag, " R5 sysReq"}, 32'(sysReq), 32'd1);
        chk({tag, " R5 sysAddr"}, sysAddr, a);
        chk({tag, " R5 stall"}, 32'(reqReady), 32'd0);
        chk({tag, " R5 wait rsp"}, 32'(rspValid), 32'd0);
        @(negedge clk);
      end
      sysAck = 1'b1; sysData = a ^ 32'hC3C3_0000;
      #1;
      chk({tag, " R6 rspValid"}, 32'(rspValid), 32'd1);
      chk({tag, " R6 rspSrc"}, 32'(rspSrc), 32'd3);
      chk({tag, " R6 rspData"}, rspData, expData(2'd3, a));
      chk({tag, " R7 fill"}, 32'(cacheFillEn), 32'd1);
      @(negedge clk);
      sysAck = 1'b0;
      #1;
      chk({tag, " R6 release"}, {30'd0, sysReq, reqReady}, 32'd1);
    end
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    #3;
    chk("R1 reset outputs", {28'd0, reqReady, sysReq, rspValid, cacheFillEn}, 32'h8);
    #20 rstN = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 post reset", {28'd0, reqReady, sysReq, rspValid, cacheFillEn}, 32'h8);

    // R1: unconfigured windows never hit
    doRead("R1 cache before cfg", 32'h1000_0000, 1'b1, 2'd2);
    doRead("R1 sys before cfg", 32'h1000_0004, 1'b0, 2'd3);

    // R10: stray acknowledge with nothing pending
    @(negedge clk);
    sysAck = 1'b1; sysData = 32'hDEAD_BEEF;
    #1;
    chk("R10 stray ack", {30'd0, rspValid, cacheFillEn}, 32'd0);
    @(negedge clk);
    sysAck = 1'b0;
    #1;
    chk("R10 no request started", {30'd0, sysReq, reqReady}, 32'd1);

    // R9 R8: SRAM 4 KiB, ROM 1 MiB with base bits under the mask
    cfgWrite(1'b0, 32'h1000_0000, 32'h0000_0FFF, 1'b1);
    cfgWrite(1'b1, 32'h1001_2345, 32'h000F_FFFF, 1'b1);

    for (int i = 0; i < 8; i++) begin
      doRead($sformatf("R2 R3 R4 R8 vec%0d", i), VEC[i][31:0], VEC[i][32], VEC[i][34:33]);
    end

    // R8 R9: disable SRAM, its addresses fall to ROM
    cfgWrite(1'b0, 32'h1000_0000, 32'h0000_0FFF, 1'b0);
    doRead("R8 disabled sram", 32'h1000_0010, 1'b1, 2'd1);
    // R9: disabling ROM leaves cache
    cfgWrite(1'b1, 32'h1000_0000, 32'h000F_FFFF, 1'b0);
    doRead("R9 rom disabled", 32'h1000_0010, 1'b1, 2'd2);
    // R9: re-enable SRAM elsewhere
    cfgWrite(1'b0, 32'h2000_0000, 32'h0000_00FF, 1'b1);
    doRead("R9 sram moved", 32'h2000_00FC, 1'b1, 2'd0);
    doRead("R8 sram end+1", 32'h2000_0100, 1'b0, 2'd3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule